// File: doc/BRIEF.md
# Segmented Dual-Mode Wide Adder

This block adds two wide operands that are cut into a fixed number of equal segments. In carry-save mode every segment adds at once in a single cycle. Each segment keeps its own carry-out in a saved-carry register. On the next carry-save addition that carry enters the segment above it, so no carry runs across the whole width. In ripple mode the block takes a new pair of operands and folds in every pending saved carry. It then walks the segments from the lowest to the highest, one per clock, and passes a real carry upward. The result is the exact binary sum.

A surrounding accumulator runs in carry-save mode for most of its work and calls one ripple pass when it needs a settled value. A segment in a ripple pass can receive both the carry from the segment below and a saved carry. Its carry-out can therefore be two, so the ripple carry is two bits wide. The block accepts a new command only while `ready_o` is high.

Top module: `dual_mode_adder`

## Requirements
- R1: After reset, `sum_o` and `carry_o` are zero, `ovf_o` is 0 and `ready_o` is 1.
- R2: With `ready_o` high, `start_i` high and `mode_i` = 0 (carry-save), the outputs update after one clock edge and `ready_o` stays high. Bit i of `carry_o` is the carry-out of segment i, and segment i covers bits i*SW up to i*SW+SW-1. The new value of `sum_o` + sum over i of `carry_o`[i]*2^(SW*(i+1)) equals A + B + sum over i < NSEG-1 of old `carry_o`[i]*2^(SW*(i+1)).
- R3: After a carry-save addition, `ovf_o` equals `carry_o`[NSEG-1]. The old top saved carry is not added anywhere.
- R4: With `ready_o` high, `start_i` high and `mode_i` = 1 (ripple), `ready_o` is low for exactly NSEG cycles after the accepting edge and then returns high.
- R5: When a ripple pass completes, `sum_o` equals (A + B + P) mod 2^W. P is the value of the saved carries at acceptance, counted as sum over all i of `carry_o`[i]*2^(SW*(i+1)).
- R6: When a ripple pass completes, `ovf_o` is 1 exactly when A + B + P is at least 2^W.
- R7: From the cycle after a ripple command is accepted, `carry_o` is zero, and it stays zero while `ready_o` is low.
- R8: `start_i` is ignored while `ready_o` is low: the ripple length and the ripple result do not change.
- R9: A segment that receives both a ripple carry and a saved carry with all-ones operands produces a carry of two, and the ripple result stays exact.
- R10: While `ready_o` is high and `start_i` is low, `sum_o`, `carry_o` and `ovf_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when ready_o is high |
| mode_i | input | 1 | 0 = carry-save addition, 1 = ripple pass |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sum_o | output | W | Segment sums, or the exact sum after a ripple pass |
| carry_o | output | NSEG | Saved carry of each segment |
| ovf_o | output | 1 | Carry out of the full width |
| ready_o | output | 1 | High when a new command can be accepted |

## Verification
Three things can meet in one cycle here. A ripple command can arrive in the cycle right after a carry-save addition, so the ripple pass must fold in carries that were saved one edge earlier. In the same kind of pass a segment can take both a ripple carry and a saved carry. The bench provokes this by issuing back-to-back carry-save additions and then a ripple command on all-ones operands. While that pass is busy it pulses `start_i` with different operands. It judges the outcome by the exact sum, the overflow bit and the busy length, all computed from the operands and the carries seen at the ports.

// File: rtl/adder_pkg.sv
package adder_pkg;
    typedef enum logic {
        MODE_SAVE   = 1'b0,
        MODE_RIPPLE = 1'b1
    } add_mode_e;
endpackage

// File: rtl/seg_adder.sv
// One segment: two SW-bit operands plus a carry-in of up to three;
// carry-out may be two when both a ripple carry and a saved carry arrive.
module seg_adder #(
    parameter int SW = 33
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic [1:0]    cin_i,
    output logic [SW-1:0] sum_o,
    output logic [1:0]    cout_o
);
    logic [SW+1:0] full;

    assign full   = {2'b00, a_i} + {2'b00, b_i} + {{SW{1'b0}}, cin_i};
    assign sum_o  = full[SW-1:0];
    assign cout_o = full[SW+1:SW];
endmodule

// File: rtl/csa_array.sv
// All segments side by side; each takes a single injected carry.
module csa_array #(
    parameter int SW   = 33,
    parameter int NSEG = 8,
    localparam int W   = SW * NSEG
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [NSEG-1:0] cin_i,
    output logic [W-1:0]    sum_o,
    output logic [NSEG-1:0] cout_o
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [1:0] c2;

        seg_adder #(.SW(SW)) u_seg (
            .a_i   (a_i[g*SW +: SW]),
            .b_i   (b_i[g*SW +: SW]),
            .cin_i ({1'b0, cin_i[g]}),
            .sum_o (sum_o[g*SW +: SW]),
            .cout_o(c2)
        );
        // with a single-bit carry-in the upper carry bit stays clear
        assign cout_o[g] = |c2;
    end
endmodule

// File: rtl/dual_mode_adder.sv
module dual_mode_adder
    import adder_pkg::*;
#(
    parameter int SW   = 33,
    parameter int NSEG = 8,
    localparam int W    = SW * NSEG,
    localparam int IDXW = (NSEG > 2) ? $clog2(NSEG) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    sum_o,
    output logic [NSEG-1:0] carry_o,
    output logic            ovf_o,
    output logic            ready_o
);
    typedef struct packed {
        logic [W-1:0]    sum;
        logic [W-1:0]    opa;
        logic [W-1:0]    opb;
        logic [NSEG-1:0] car;
        logic [NSEG-1:0] pend;
        logic            ovf;
        logic            busy;
        logic [IDXW-1:0] idx;
        logic [1:0]      rc;
    } state_t;

    state_t q, d;

    // carry-save path
    logic [NSEG-1:0] cs_cin;
    logic [W-1:0]    cs_sum;
    logic [NSEG-1:0] cs_cout;

    assign cs_cin = {q.car[NSEG-2:0], 1'b0};

    csa_array #(.SW(SW), .NSEG(NSEG)) u_csa (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cs_cin),
        .sum_o (cs_sum),
        .cout_o(cs_cout)
    );

    // ripple path: one segment per cycle
    logic [NSEG-1:0] pend_in;
    logic [SW-1:0]   r_a, r_b, r_sum;
    logic [1:0]      r_cin, r_cout;

    assign pend_in = {q.pend[NSEG-2:0], 1'b0};
    assign r_a     = q.opa[int'(q.idx)*SW +: SW];
    assign r_b     = q.opb[int'(q.idx)*SW +: SW];
    assign r_cin   = q.rc + {1'b0, pend_in[q.idx]};

    seg_adder #(.SW(SW)) u_rip (
        .a_i   (r_a),
        .b_i   (r_b),
        .cin_i (r_cin),
        .sum_o (r_sum),
        .cout_o(r_cout)
    );

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                if (add_mode_e'(mode_i) == MODE_SAVE) begin
                    d.sum = cs_sum;
                    d.car = cs_cout;
                    d.ovf = cs_cout[NSEG-1];
                end else begin
                    d.opa  = a_i;
                    d.opb  = b_i;
                    d.pend = q.car;
                    d.car  = '0;
                    d.busy = 1'b1;
                    d.idx  = '0;
                    d.rc   = 2'd0;
                end
            end
        end else begin
            d.sum[int'(q.idx)*SW +: SW] = r_sum;
            d.rc = r_cout;
            if (q.idx == IDXW'(NSEG - 1)) begin
                d.busy = 1'b0;
                d.ovf  = (|r_cout) | q.pend[NSEG-1];
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sum_o   = q.sum;
    assign carry_o = q.car;
    assign ovf_o   = q.ovf;
    assign ready_o = !q.busy;
endmodule

// File: rtl/dual_mode_adder_chk.sv
module dual_mode_adder_chk #(
    parameter int SW   = 33,
    parameter int NSEG = 8,
    localparam int W   = SW * NSEG,
    localparam int CW  = $clog2(NSEG + 1) + 1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            mode_i,
    input logic [W-1:0]    sum_o,
    input logic [NSEG-1:0] carry_o,
    input logic            ovf_o,
    input logic            ready_o
);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       low_cnt <= '0;
        else if (ready_o)  low_cnt <= '0;
        else               low_cnt <= low_cnt + 1'b1;
    end

    a_r2_save_keeps_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && start_i && !mode_i) |=> ready_o);

    a_r3_ovf_is_top_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && start_i && !mode_i) |=> (ovf_o == carry_o[NSEG-1]));

    a_r4_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_o) |-> $past(start_i && mode_i));

    a_r4_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> (low_cnt < CW'(NSEG)));

    a_r4_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> (low_cnt == CW'(NSEG)));

    a_r7_carries_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> (carry_o == '0));

    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !start_i) |=> ($stable(sum_o) && $stable(carry_o) && $stable(ovf_o) && ready_o));
endmodule

bind dual_mode_adder dual_mode_adder_chk #(.SW(SW), .NSEG(NSEG)) u_chk (.*);

// File: tb/tb_dual_mode_adder.sv
`timescale 1ns/1ps
module tb_dual_mode_adder;
    localparam int SW   = 33;
    localparam int NSEG = 8;
    localparam int W    = SW * NSEG;
    localparam int NV   = 6;

    localparam logic [W-1:0] VA [NV] = '{
        {W{1'b0}},
        {8{33'h1FFFFFFFF}},
        {66{4'hA}},
        {8{33'h100000000}},
        {33{8'h3C}},
        {8{33'h0FFFF0001}}
    };
    localparam logic [W-1:0] VB [NV] = '{
        {W{1'b0}},
        {{(W-1){1'b0}}, 1'b1},
        {66{4'h5}},
        {8{33'h100000000}},
        {33{8'hE7}},
        {8{33'h1000FFFFF}}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode = 1'b0;
    logic [W-1:0]    a = '0, b = '0;
    logic [W-1:0]    sum;
    logic [NSEG-1:0] carry;
    logic            ovf, ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_mode_adder #(.SW(SW), .NSEG(NSEG)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .a_i(a), .b_i(b), .sum_o(sum), .carry_o(carry), .ovf_o(ovf), .ready_o(ready)
    );

    function automatic logic [W+3:0] carry_val(input logic [NSEG-1:0] c, input bit with_top);
        logic [W+3:0] r = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (c[i] && (with_top || i < NSEG - 1))
                r = r + ((W+4)'(1) << (SW * (i + 1)));
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_save(input logic [W-1:0] va, input logic [W-1:0] vb);
        logic [W+3:0] exp, act;
        exp = {4'b0, va} + {4'b0, vb} + carry_val(carry, 1'b0);
        @(negedge clk);
        start = 1'b1; mode = 1'b0; a = va; b = vb;
        @(negedge clk);
        start = 1'b0;
        act = {4'b0, sum} + carry_val(carry, 1'b1);
        chk(act == exp, "R2 save value", act, exp);
        chk(ready == 1'b1, "R2 ready high", ready, 1);
        chk(ovf == carry[NSEG-1], "R3 ovf", ovf, carry[NSEG-1]);
    endtask

    task automatic do_ripple(input logic [W-1:0] va, input logic [W-1:0] vb, input bit poke);
        logic [W+3:0] full;
        int cnt;
        full = {4'b0, va} + {4'b0, vb} + carry_val(carry, 1'b1);
        @(negedge clk);
        start = 1'b1; mode = 1'b1; a = va; b = vb;
        @(negedge clk);
        start = 1'b0;
        chk(carry == '0, "R7 carries cleared", carry, 0);
        cnt = 0;
        while (!ready && cnt < 40) begin
            cnt++;
            if (poke && cnt == 2) begin
                start = 1'b1; mode = 1'b0; a = ~va; b = {W{1'b1}};
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == NSEG, poke ? "R8 busy length" : "R4 busy length", cnt, NSEG);
        chk(sum == full[W-1:0], poke ? "R8 ripple sum" : "R5 ripple sum", sum, full[W-1:0]);
        chk(ovf == (|full[W+3:W]), "R6 ripple ovf", ovf, |full[W+3:W]);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0]    hs;
        logic [NSEG-1:0] hc;
        logic            ho;
        logic [W+3:0]    full;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sum == '0, "R1 sum", sum, 0);
        chk(carry == '0, "R1 carry", carry, 0);
        chk(ovf == 1'b0 && ready == 1'b1, "R1 flags", {ovf, ready}, 2'b01);

        // table walk: save pass, then ripple pass with zero operands
        for (int v = 0; v < NV; v++) begin
            do_save(VA[v], VB[v]);
            do_ripple('0, '0, 1'b0);
            chk(carry == '0, "R7 after ripple", carry, 0);
        end

        // R10 idle hold with operands moving and start low
        do_save(VA[5], VB[4]);
        hs = sum; hc = carry; ho = ovf;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a = VA[k]; b = VB[k]; mode = k[0];
        end
        @(negedge clk);
        chk(sum == hs && carry == hc && ovf == ho, "R10 idle hold", sum, hs);

        // back-to-back save additions: carries injected into the next segment
        do_save(VA[1], VB[1]);
        do_save(VA[3], VB[3]);
        // ripple right after, with a start pulse while busy (R8) and
        // all-ones operands so a segment sees two incoming carries (R9)
        do_ripple({W{1'b1}}, {W{1'b1}}, 1'b1);

        // R9 pure double-carry case
        do_save({W{1'b1}}, {W{1'b1}});
        full = {4'b0, {W{1'b1}}} + {4'b0, {W{1'b1}}} + carry_val(carry, 1'b1);
        do_ripple({W{1'b1}}, {W{1'b1}}, 1'b0);
        chk(sum == full[W-1:0], "R9 double carry sum", sum, full[W-1:0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule